// File: doc/BRIEF.md
# Inter-Processor Message Interrupt Controller

This block lets each core of a small multiprocessor send a short message interrupt to another core. Every core owns two 32-bit registers on a simple register bus: a control word and a status word. When a core writes its control word with the generate command set, the destination core's status word receives a pending flag, the sender's core number and a 16-bit payload. The destination core's interrupt line then rises. When the same core, or any later write, carries the acknowledge command, the writer's own pending flag clears and its interrupt line falls.

Each core has one level-sensitive interrupt output, and it follows that core's pending flag. The core count is a parameter from 1 to 4. An address or destination that names a core beyond the configured count is ignored. A single control write may do both commands at once. The message is always posted first and the acknowledge applied after it, so a core that targets itself with both commands ends with its flag cleared.

Top module: `ipi_mailbox`

## Requirements
- R1: The register address is decoded as follows. Bits [4:3] select the core, bit 2 selects control (0) or status (1), and bits [1:0] are ignored. `req_ready` is always high. An accepted read raises `rd_valid` for one cycle after its clock edge, with the word on `rd_data`.
- R2: A write to a core's control address stores the full 32-bit word, and reading it back returns that word.
- R3: A control write from core S with bit 30 set and bits [29:16] naming an existing core D overwrites D's status with bit 31 = 0, bit 30 = 1, bits [29:16] = S and bits [15:0] = the write's low 16 bits. A later message overwrites an earlier one.
- R4: A control write with bit 31 set clears bit 30 of the writer's own status and leaves all other status bits unchanged.
- R5: Within one write, the message is posted before the acknowledge is applied. If a core targets itself with both bits set, its flag ends cleared while its sender and payload fields hold the new values.
- R6: A write to a status address changes no register and no interrupt output.
- R7: A core index (address) or destination index at or above NUM_CORES is ignored for writes, and reads of such an address return zero.
- R8: Each interrupt output equals its core's status bit 30. It changes only at the clock edge that accepts a write.
- R9: After reset, every control word, status word and interrupt output is zero.
- R10: NUM_CORES may range from 1 to 4, and a value outside that range stops elaboration. `irq_o` has one bit per core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rd_data | output | 32 | Read data |
| irq_o | output | NUM_CORES | Per-core interrupt level |

## Verification
Posting a message and acknowledging can fall in the same write. They may hit the same core, when a core targets itself, or two different cores, when a core sends while acknowledging its own flag. The bench provokes both cases: a self-targeted write with both command bits set, and a write from a core with its flag pending that both sends to another core and acknowledges. It judges the result by reading back every status word and by comparing each interrupt line with a behavioural model on every clock.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int MAX_CORES  = 4;
    localparam int WORD_W     = 32;
    localparam int ID_W       = 14;
    localparam int PAYLOAD_W  = 16;
    localparam int BIT_ACK    = 31;
    localparam int BIT_GEN    = 30;
    localparam int BIT_PEND   = 30;
    localparam int DST_LO     = 16;
    localparam int SEL_BIT    = 2;
    localparam int IDX_LO     = 3;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] status;
        logic              irq;
    } slot_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } rd_stage_t;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 1,
    parameter int ADDR_W    = 5
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    output logic [NUM_CORES-1:0] ctrl_we,
    output logic [NUM_CORES-1:0] gen_oh,
    output logic [NUM_CORES-1:0] ack_oh,
    output logic [ID_W-1:0]      src_id,
    output logic                 rd_en,
    output logic                 rd_hit,
    output logic                 rd_status,
    output logic [ADDR_W-IDX_LO-1:0] rd_idx
);
    localparam int IDX_W = ADDR_W - IDX_LO;

    logic [IDX_W-1:0] idx;
    logic [ID_W-1:0]  dst;
    logic             idx_ok;
    logic             dst_ok;
    logic             is_status;
    logic             ctrl_wr;
    logic             unused_low;

    assign unused_low = ^req_addr[SEL_BIT-1:0];

    always_comb begin
        idx       = req_addr[ADDR_W-1:IDX_LO];
        is_status = req_addr[SEL_BIT];
        dst       = req_wdata[DST_LO +: ID_W];
        idx_ok    = int'(idx) < NUM_CORES;
        dst_ok    = int'(dst) < NUM_CORES;
        ctrl_wr   = req_valid && req_write && !is_status && idx_ok;
        src_id    = ID_W'(idx);
        rd_en     = req_valid && !req_write;
        rd_hit    = idx_ok;
        rd_status = is_status;
        rd_idx    = idx;
    end

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_dec
        assign ctrl_we[i] = ctrl_wr && (int'(idx) == i);
        assign gen_oh[i]  = ctrl_wr && req_wdata[BIT_GEN] && dst_ok && (int'(dst) == i);
        assign ack_oh[i]  = ctrl_wr && (int'(idx) == i) && req_wdata[BIT_ACK];
    end
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              gen_hit,
    input  logic              ack_hit,
    input  logic [ID_W-1:0]   src_id,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] status_q,
    output logic              irq_q
);
    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ctrl_we) begin
            s_d.ctrl = wdata;
        end
        // message first, acknowledge second
        if (gen_hit) begin
            s_d.status = {1'b0, 1'b1, src_id, wdata[PAYLOAD_W-1:0]};
        end
        if (ack_hit) begin
            s_d.status[BIT_PEND] = 1'b0;
        end
        s_d.irq = s_d.status[BIT_PEND];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_q   = s_q.ctrl;
    assign status_q = s_q.status;
    assign irq_q    = s_q.irq;
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 1,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    output logic [NUM_CORES-1:0] irq_o
);
    localparam int IDX_W = ADDR_W - IDX_LO;

    if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_count
        $error("ipi_mailbox: NUM_CORES must lie in 1..4");
    end

    logic [NUM_CORES-1:0] ctrl_we, gen_oh, ack_oh;
    logic [ID_W-1:0]      src_id;
    logic                 rd_en, rd_hit, rd_status;
    logic [IDX_W-1:0]     rd_idx;
    logic [WORD_W-1:0]    ctrl_w   [NUM_CORES];
    logic [WORD_W-1:0]    status_w [NUM_CORES];
    rd_stage_t            rd_d, rd_q;

    ipi_addr_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ctrl_we   (ctrl_we),
        .gen_oh    (gen_oh),
        .ack_oh    (ack_oh),
        .src_id    (src_id),
        .rd_en     (rd_en),
        .rd_hit    (rd_hit),
        .rd_status (rd_status),
        .rd_idx    (rd_idx)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
        ipi_core_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (ctrl_we[i]),
            .gen_hit  (gen_oh[i]),
            .ack_hit  (ack_oh[i]),
            .src_id   (src_id),
            .wdata    (req_wdata),
            .ctrl_q   (ctrl_w[i]),
            .status_q (status_w[i]),
            .irq_q    (irq_o[i])
        );
    end

    always_comb begin
        rd_d.valid = rd_en;
        rd_d.data  = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (rd_en && rd_hit && int'(rd_idx) == i) begin
                rd_d.data = rd_status ? status_w[i] : ctrl_w[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign req_ready = 1'b1;
    assign rd_valid  = rd_q.valid;
    assign rd_data   = rd_q.data;
endmodule

// File: rtl/ipi_mailbox_checks.sv
module ipi_mailbox_checks #(
    parameter int NUM_CORES = 1,
    parameter int ADDR_W    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [31:0]          req_wdata,
    input logic                 rd_valid,
    input logic [31:0]          rd_data,
    input logic [NUM_CORES-1:0] irq_o
);
    logic [NUM_CORES-1:0] post_oh, drop_oh;
    logic                 any_wr, stat_wr, oor_rd;
    logic                 unused_chk;

    assign unused_chk = ^{req_ready, req_addr[1:0]};

    always_comb begin
        any_wr  = req_valid && req_write && !req_addr[2]
                  && int'(req_addr[ADDR_W-1:3]) < NUM_CORES;
        stat_wr = req_valid && req_write && req_addr[2];
        oor_rd  = req_valid && !req_write && int'(req_addr[ADDR_W-1:3]) >= NUM_CORES;
        for (int i = 0; i < NUM_CORES; i++) begin
            drop_oh[i] = any_wr && req_wdata[31] && int'(req_addr[ADDR_W-1:3]) == i;
            post_oh[i] = any_wr && req_wdata[30] && int'(req_wdata[29:16]) == i
                         && !drop_oh[i];
        end
    end

    // R3: a posted message raises the destination line
    a_r3_post_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (post_oh != '0) |=> ((irq_o & $past(post_oh)) == $past(post_oh)));

    // R4: acknowledge lowers the writer's line
    a_r4_ack_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_oh != '0) |=> ((irq_o & $past(drop_oh)) == '0));

    // R6: status writes change no line
    a_r6_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (irq_o == $past(irq_o)));

    // R7: out-of-range reads return zero
    a_r7_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        oor_rd |=> (rd_valid && rd_data == '0));

    // R8: a line rises only after a message to it
    a_r8_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~$past(irq_o)) & ~$past(post_oh)) == '0);

    // R1: rd_valid follows an accepted read by one cycle
    a_r1_rd_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R9: reset leaves every line low
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));
endmodule

bind ipi_mailbox ipi_mailbox_checks #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ipi_mailbox_bench.sv
module ipi_mailbox_bench;
    localparam int N  = 3;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic [N-1:0]  irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit live   = 0;

    int unsigned ctrl_m [4];
    int unsigned stat_m [4];

    always #2.5 clk = ~clk;

    ipi_mailbox #(.NUM_CORES(N), .ADDR_W(AW)) u_ipi_mailbox (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_irq();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = stat_m[i][30];
        return v;
    endfunction

    // R8: interrupt lines compared with the model on every clock
    always @(negedge clk) begin
        if (live) check("R8 irq level", 32'(irq_o), 32'(model_irq()));
    end

    function automatic void model_write(logic [AW-1:0] a, logic [31:0] d);
        int src = int'(a[AW-1:3]);
        int dst = int'(d[29:16]);
        if (a[2] || src >= N) return;
        ctrl_m[src] = d;
        if (d[30] && dst < N) stat_m[dst] = {2'b01, 14'(src), d[15:0]};
        if (d[31]) stat_m[src][30] = 1'b0;
    endfunction

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(string tag, logic [AW-1:0] a);
        int idx = int'(a[AW-1:3]);
        logic [31:0] exp = (idx < N) ? (a[2] ? stat_m[idx] : ctrl_m[idx]) : 32'h0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " rd_valid"}, 32'(rd_valid), 32'h1);
        check(tag, rd_data, exp);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin ctrl_m[i] = 0; stat_m[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 irq after reset", 32'(irq_o), 32'h0);
        rst_n = 1'b1;
        live = 1;
        check("R1 req_ready", 32'(req_ready), 32'h1);
        check("R10 irq width", $bits(irq_o), N);
        // R9: all registers zero
        for (int c = 0; c < N; c++) begin
            rd("R9 ctrl reset", AW'(c * 8));
            rd("R9 status reset", AW'(c * 8 + 4));
        end
        // R2: plain control store
        wr(5'd0, 32'h0000_1234);
        rd("R2 ctrl0 readback", 5'd0);
        // R7 and R2: destination 5 out of range, word still stored
        wr(5'd8, 32'h4005_ABCD);
        rd("R2 ctrl1 full word", 5'd8);
        rd("R7 status0 untouched", 5'd4);
        // R3: core0 -> core2
        wr(5'd0, 32'h4002_BEEF);
        rd("R3 status2 message", 5'd20);
        check("R3 irq2 raised", 32'(irq_o[2]), 32'h1);
        // R3: overwrite by core1
        wr(5'd8, 32'h4002_0101);
        rd("R3 status2 overwrite", 5'd20);
        // R4: core2 acknowledges
        wr(5'd16, 32'h8000_0000);
        rd("R4 status2 after ack", 5'd20);
        check("R4 irq2 low", 32'(irq_o[2]), 32'h0);
        // R6: status address write ignored
        wr(5'd12, 32'hFFFF_FFFF);
        rd("R6 status1 unchanged", 5'd12);
        rd("R6 ctrl1 unchanged", 5'd8);
        // R5: self-target with both commands
        wr(5'd8, 32'hC001_7777);
        rd("R5 self status1", 5'd12);
        check("R5 irq1 low", 32'(irq_o[1]), 32'h0);
        // R5: send and acknowledge own flag in one write
        wr(5'd16, 32'h4000_0055);
        check("R3 irq0 raised", 32'(irq_o[0]), 32'h1);
        wr(5'd0, 32'hC002_0066);
        rd("R5 status0 acked", 5'd4);
        rd("R5 status2 posted", 5'd20);
        check("R5 irq pattern", 32'(irq_o), 32'h4);
        // R7: core index 3 does not exist
        rd("R7 oor read", 5'd24);
        rd("R7 oor status read", 5'd28);
        wr(5'd24, 32'h4000_0099);
        rd("R7 status0 after oor write", 5'd4);
        // R1: low address bits ignored
        rd("R1 low bits ignored", 5'd23);
        repeat (3) @(posedge clk);
        done = 1;
        live = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule